// File: doc/BRIEF.md
# Sign-Driven Digital Gain Tap

This block sits on the playback sample path and folds a programmable feedback term into each sample. Every accepted sample arrives with one bit from a sigma-delta modulator's output stream. That bit picks the operation. When it is 1, a signed 16-bit coefficient is added to the sample. When it is 0, the coefficient is subtracted. No multiplier is involved. The corrected sample leaves the block one clock later. The result is clamped to the 16-bit signed range instead of wrapping.

The coefficient is a two's-complement Q1.15 fraction. Software writes it as two bytes through separate write strobes, one for the upper byte and one for the lower byte. Each byte goes into a staging register. Once both halves have been written, the assembled value waits until the next accepted sample and becomes live there. A sample never sees a coefficient with only one half updated.

Top module: `sd_gain_tap`

## Requirements
- R1: After reset, `smp_valid_o` is 0, `smp_o` is 0x0000 and the live coefficient is 0x0000, so samples pass through unchanged.
- R2: `smp_valid_o` is `smp_valid_i` delayed by exactly one clock.
- R3: With `mod_bit_i` = 1, the output is the saturated sum of the sample and the coefficient. The coefficient is Q1.15: 0x8000 is -1.0, 0xC000 is -0.5, 0x4000 is +0.5 and 0x7FFF is just under +1.0.
- R4: With `mod_bit_i` = 0, the output is the saturated difference, sample minus coefficient.
- R5: A result above 0x7FFF is clamped to 0x7FFF, and a result below 0x8000 is clamped to 0x8000. The result never wraps.
- R6: Subtracting the coefficient 0x8000 adds +1.0 without an intermediate overflow. For example, sample 0xC000 gives 0x4000 and sample 0x8000 gives 0x0000.
- R7: A live coefficient of 0x0000 returns the input sample unchanged for either modulator bit.
- R8: Writing only one half, once or several times, leaves the live coefficient unchanged. The upper byte is coefficient bits 15:8 and the lower byte is bits 7:0.
- R9: A coefficient whose second half is written in the cycle before or in the same cycle as an accepted sample is applied as follows:
  - Second half written in an earlier cycle: that sample uses the new value.
  - Second half written in the same cycle: that sample uses the previous value, and the next sample uses the new value.
- R10: While `smp_valid_i` is low, `smp_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Input sample qualifier |
| smp_i | input | 16 | Interpolator sample, two's complement |
| mod_bit_i | input | 1 | Modulator bit: 1 adds, 0 subtracts |
| coef_hi_we_i | input | 1 | Write strobe for coefficient upper byte |
| coef_hi_i | input | 8 | Coefficient bits 15:8 |
| coef_lo_we_i | input | 1 | Write strobe for coefficient lower byte |
| coef_lo_i | input | 8 | Coefficient bits 7:0 |
| smp_valid_o | output | 1 | Output sample qualifier |
| smp_o | output | 16 | Corrected, saturated sample |

## Verification
Two things can happen in the same clock: the write that completes a coefficient, and the acceptance of a sample. The bench drives the final byte strobe in the same cycle as a valid sample and expects two outcomes:
- That sample is corrected with the old coefficient.
- The following sample is corrected with the new one.

The bench also applies a lone half-write between samples and expects no change. Every expected output is computed arithmetically from a clamped sum or difference over a sweep of coefficients, samples and both modulator bits.

// File: rtl/sd_gain_tap_pkg.sv
package sd_gain_tap_pkg;
  localparam int unsigned SMP_W  = 16;
  localparam int unsigned HALF_W = 8;

  typedef enum logic {
    OP_SUB = 1'b0,
    OP_ADD = 1'b1
  } tap_op_e;
endpackage

// File: rtl/sd_gain_tap_coef.sv
module sd_gain_tap_coef #(
  parameter int unsigned HALF_W = sd_gain_tap_pkg::HALF_W,
  localparam int unsigned COEF_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_we_i,
  input  logic [HALF_W-1:0] hi_i,
  input  logic              lo_we_i,
  input  logic [HALF_W-1:0] lo_i,
  input  logic              take_i,
  output logic [COEF_W-1:0] coef_eff_o,
  output logic [COEF_W-1:0] coef_act_o
);
  logic [HALF_W-1:0] hi_stg_q, lo_stg_q;
  logic              hi_seen_q, lo_seen_q;
  logic [COEF_W-1:0] pend_q, act_q;
  logic              pend_vld_q;
  logic              done;

  // both halves present once this cycle's strobes are counted
  assign done = (hi_seen_q | hi_we_i) & (lo_seen_q | lo_we_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_stg_q  <= '0;
      lo_stg_q  <= '0;
      hi_seen_q <= 1'b0;
      lo_seen_q <= 1'b0;
    end else begin
      if (hi_we_i) hi_stg_q <= hi_i;
      if (lo_we_i) lo_stg_q <= lo_i;
      hi_seen_q <= done ? 1'b0 : (hi_seen_q | hi_we_i);
      lo_seen_q <= done ? 1'b0 : (lo_seen_q | lo_we_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      act_q      <= '0;
    end else begin
      if (take_i && pend_vld_q) act_q <= pend_q;
      if (done) begin
        pend_q     <= {hi_we_i ? hi_i : hi_stg_q, lo_we_i ? lo_i : lo_stg_q};
        pend_vld_q <= 1'b1;
      end else if (take_i) begin
        pend_vld_q <= 1'b0;
      end
    end
  end

  assign coef_eff_o = pend_vld_q ? pend_q : act_q;
  assign coef_act_o = act_q;
endmodule

// File: rtl/sd_gain_tap_addsub.sv
module sd_gain_tap_addsub #(
  parameter int unsigned W = sd_gain_tap_pkg::SMP_W
) (
  input  logic                    op_add_i,
  input  logic [W-1:0]            a_i,
  input  logic [W-1:0]            c_i,
  output logic [W-1:0]            y_o
);
  localparam int unsigned EW = W + 1;
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic [EW-1:0] a_x, c_x, sum;
  logic          ovf;

  assign a_x = {a_i[W-1], a_i};
  assign c_x = {c_i[W-1], c_i};
  // one guard bit: -(-1.0) fits before clamping
  assign sum = op_add_i ? (a_x + c_x) : (a_x - c_x);
  assign ovf = sum[EW-1] ^ sum[W-1];

  always_comb begin
    if (ovf) y_o = sum[EW-1] ? NEG_MIN : POS_MAX;
    else     y_o = sum[W-1:0];
  end
endmodule

// File: rtl/sd_gain_tap.sv
module sd_gain_tap
  import sd_gain_tap_pkg::*;
#(
  parameter int unsigned HALF_W_P = sd_gain_tap_pkg::HALF_W,
  localparam int unsigned DW = 2 * HALF_W_P
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                smp_valid_i,
  input  logic [DW-1:0]       smp_i,
  input  logic                mod_bit_i,
  input  logic                coef_hi_we_i,
  input  logic [HALF_W_P-1:0] coef_hi_i,
  input  logic                coef_lo_we_i,
  input  logic [HALF_W_P-1:0] coef_lo_i,
  output logic                smp_valid_o,
  output logic [DW-1:0]       smp_o
);
  logic [DW-1:0] coef_eff, coef_act, tap_res;
  tap_op_e       op;

  assign op = mod_bit_i ? OP_ADD : OP_SUB;

  sd_gain_tap_coef #(.HALF_W(HALF_W_P)) i_coef (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hi_we_i    (coef_hi_we_i),
    .hi_i       (coef_hi_i),
    .lo_we_i    (coef_lo_we_i),
    .lo_i       (coef_lo_i),
    .take_i     (smp_valid_i),
    .coef_eff_o (coef_eff),
    .coef_act_o (coef_act)
  );

  sd_gain_tap_addsub #(.W(DW)) i_addsub (
    .op_add_i (op == OP_ADD),
    .a_i      (smp_i),
    .c_i      (coef_eff),
    .y_o      (tap_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_valid_o <= 1'b0;
      smp_o       <= '0;
    end else begin
      smp_valid_o <= smp_valid_i;
      if (smp_valid_i) smp_o <= tap_res;
    end
  end
endmodule

// File: rtl/sd_gain_tap_chk.sv
module sd_gain_tap_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          smp_valid_i,
  input logic [DW-1:0] smp_i,
  input logic          mod_bit_i,
  input logic          smp_valid_o,
  input logic [DW-1:0] smp_o,
  input logic [DW-1:0] coef_eff,
  input logic [DW-1:0] coef_act
);
  a_r2_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> smp_valid_o == $past(smp_valid_i));

  a_r10_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> $stable(smp_o));

  a_r7_zero_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && coef_eff == '0) |=> smp_o == $past(smp_i));

  a_r5_no_wrap_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && mod_bit_i && !smp_i[DW-1] && !coef_eff[DW-1]) |=> !smp_o[DW-1]);

  a_r5_no_wrap_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && !mod_bit_i && smp_i[DW-1] && !coef_eff[DW-1]) |=> smp_o[DW-1]);

  a_r9_commit_on_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> $stable(coef_act));
endmodule

bind sd_gain_tap sd_gain_tap_chk #(.DW(DW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_valid_i (smp_valid_i),
  .smp_i       (smp_i),
  .mod_bit_i   (mod_bit_i),
  .smp_valid_o (smp_valid_o),
  .smp_o       (smp_o),
  .coef_eff    (coef_eff),
  .coef_act    (coef_act)
);

// File: tb/test_sd_gain_tap.sv
`timescale 1ns/1ps
module test_sd_gain_tap;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic [15:0] smp_i = '0;
  logic        mod_bit_i = 1'b0;
  logic        coef_hi_we_i = 1'b0;
  logic [7:0]  coef_hi_i = '0;
  logic        coef_lo_we_i = 1'b0;
  logic [7:0]  coef_lo_i = '0;
  logic        smp_valid_o;
  logic [15:0] smp_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  sd_gain_tap i_sd_gain_tap (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .smp_valid_i  (smp_valid_i),
    .smp_i        (smp_i),
    .mod_bit_i    (mod_bit_i),
    .coef_hi_we_i (coef_hi_we_i),
    .coef_hi_i    (coef_hi_i),
    .coef_lo_we_i (coef_lo_we_i),
    .coef_lo_i    (coef_lo_i),
    .smp_valid_o  (smp_valid_o),
    .smp_o        (smp_o)
  );

  function automatic logic [15:0] model(logic [15:0] s, logic [15:0] c, logic m);
    int r;
    r = m ? (int'($signed(s)) + int'($signed(c))) : (int'($signed(s)) - int'($signed(c)));
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r[15:0];
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_hi(logic [7:0] b);
    @(negedge clk_i); coef_hi_we_i = 1'b1; coef_hi_i = b;
    @(negedge clk_i); coef_hi_we_i = 1'b0;
  endtask

  task automatic wr_lo(logic [7:0] b);
    @(negedge clk_i); coef_lo_we_i = 1'b1; coef_lo_i = b;
    @(negedge clk_i); coef_lo_we_i = 1'b0;
  endtask

  // one sample, result checked one clock later
  task automatic send(string req, logic [15:0] s, logic m, logic [15:0] c);
    @(negedge clk_i); smp_valid_i = 1'b1; smp_i = s; mod_bit_i = m;
    @(negedge clk_i); smp_valid_i = 1'b0;
    chk({req, " valid"}, {15'd0, smp_valid_o}, 16'd1);
    chk(req, smp_o, model(s, c, m));
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] coefs [8];
    logic [15:0] cur;
    coefs = '{16'h8000, 16'hC000, 16'h0000, 16'h4000, 16'h7FFF, 16'h0001, 16'hFFFF, 16'h9000};
    cur = 16'h0000;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 valid", {15'd0, smp_valid_o}, 16'd0);
    chk("R1 data", smp_o, 16'h0000);
    rst_ni = 1'b1;
    send("R1 coef zero", 16'h1234, 1'b1, 16'h0000);
    send("R7 zero sub", 16'h8001, 1'b0, 16'h0000);

    // R2 one-cycle latency and R10 hold
    @(negedge clk_i);
    chk("R2 valid drops", {15'd0, smp_valid_o}, 16'd0);
    chk("R10 hold", smp_o, 16'h8001);
    @(negedge clk_i); smp_i = 16'h5555; mod_bit_i = 1'b1;
    @(negedge clk_i);
    chk("R10 idle input ignored", smp_o, 16'h8001);

    // sweep: R3 add, R4 sub, R5 clamp, R6, R7
    foreach (coefs[k]) begin
      wr_hi(coefs[k][15:8]);
      wr_lo(coefs[k][7:0]);
      cur = coefs[k];
      for (int i = 0; i <= 33; i++) begin
        logic [15:0] s;
        s = (i == 32) ? 16'h7FFF : (i == 33) ? 16'h8000 : 16'(i * 16'h0800);
        send("R3 add", s, 1'b1, cur);
        send("R4 sub", s, 1'b0, cur);
      end
    end

    // R5 explicit clamps, R6 minus -1.0
    wr_hi(8'h40); wr_lo(8'h00); cur = 16'h4000;
    send("R5 pos clamp", 16'h7000, 1'b1, cur);
    chk("R5 pos value", smp_o, 16'h7FFF);
    send("R5 neg clamp", 16'h9000, 1'b0, cur);
    chk("R5 neg value", smp_o, 16'h8000);
    wr_hi(8'h80); wr_lo(8'h00); cur = 16'h8000;
    send("R6 sub -1", 16'hC000, 1'b0, cur);
    chk("R6 value a", smp_o, 16'h4000);
    send("R6 sub -1 b", 16'h8000, 1'b0, cur);
    chk("R6 value b", smp_o, 16'h0000);

    // R8 lone half-writes keep old coefficient
    wr_hi(8'h12);
    send("R8 half hi", 16'h0000, 1'b1, cur);
    wr_hi(8'h21);
    send("R8 half hi twice", 16'h0100, 1'b1, cur);
    wr_lo(8'h34); cur = 16'h2134;
    send("R8 assembled", 16'h0000, 1'b1, cur);
    chk("R8 byte order", smp_o, 16'h2134);

    // R9 completing write in the same cycle as a sample
    wr_hi(8'hC0);
    @(negedge clk_i);
    smp_valid_i = 1'b1; smp_i = 16'h0000; mod_bit_i = 1'b1;
    coef_lo_we_i = 1'b1; coef_lo_i = 8'h00;
    @(negedge clk_i);
    smp_valid_i = 1'b0; coef_lo_we_i = 1'b0;
    chk("R9 same cycle uses old", smp_o, 16'h2134);
    cur = 16'hC000;
    send("R9 next uses new", 16'h0000, 1'b1, cur);
    chk("R9 new value", smp_o, 16'hC000);

    // R9 back-to-back samples after completion
    wr_hi(8'h00); wr_lo(8'h10); cur = 16'h0010;
    @(negedge clk_i); smp_valid_i = 1'b1; smp_i = 16'h0100; mod_bit_i = 1'b0;
    @(negedge clk_i); smp_i = 16'h0200; mod_bit_i = 1'b1;
    chk("R9 first after write", smp_o, 16'h00F0);
    @(negedge clk_i); smp_valid_i = 1'b0;
    chk("R9 second keeps new", smp_o, 16'h0210);
    chk("R2 back-to-back valid", {15'd0, smp_valid_o}, 16'd1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule